// File: doc/BRIEF.md
# Word-Serial Montgomery Multiplier

This block computes the Montgomery product A·B·2^-n mod N for operands of n bits, where n is chosen at run time. The operands and the modulus are first written into an internal word memory through a host port, 32 bits at a time. A start pulse then launches the operation. The multiplier steps through the digits of A one 32-bit word at a time, least significant first. For each digit it folds in one multiple of B and one multiple of N, and the multiple of N is chosen with a negated inverse constant that the caller supplies. A final conditional subtraction brings the value below N. The result is written into a separate region of the same memory, where the host reads it back once the block is idle again.

The caller prepares the Montgomery constant, the operands and any conversion into or out of Montgomery form. The block only performs the reduction product. If the requested width is not legal, the block reports an error at once and touches nothing.

Top module: `mont_mul`

## Requirements
- R1: For a legal width n, an odd modulus N with bit n-1 set, operands A, B < N, and ninv = -N^-1 mod 2^32, the result region holds A·B·2^-n mod N as n/32 little-endian words once done pulses.
- R2: A width is legal when it is a multiple of 128 and lies in [256, MAX_BITS], where MAX_BITS is itself at most 32768. A start with an illegal width raises done and err on the next cycle, busy never rises, and the result region keeps its contents.
- R3: host_addr splits into a 2-bit region select in its top bits (0 = A, 1 = B, 2 = N, 3 = result) and a word index below it, with word 0 the least significant. host_rdata shows the addressed word one cycle after the address is applied.
- R4: A start with a legal width while busy is low raises busy on the next cycle. busy stays high until the cycle in which done pulses, and done is never high together with busy.
- R5: err rises only together with done. It is low after any accepted legal start and after reset.
- R6: Host writes are ignored while busy is high.
- R7: The result is always strictly below N, including the largest operands A = B = N-1.
- R8: width_bits and ninv are sampled only at an accepted start. Changes while busy have no effect on the result.
- R9: A zero operand A gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken when busy is low |
| width_bits | input | 16 | Operand width n in bits |
| ninv | input | 32 | -N^-1 mod 2^32 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start had an illegal width |
| host_we | input | 1 | Host word write enable |
| host_addr | input | IW+2 (8 by default) | Region select and word index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle latency |

## Verification
The bench compares results against a bit-serial reduction model at 256 and 512 bits, using random operands, a zero operand and the maximal operands N-1.
- A design that skipped or misjudged the final subtraction would leave a value in [N, 2N) for some of these operands.
- A design that dropped the carry into the extra top word would corrupt the upper words.

Widths of 128, 320 and 2176 are offered to check that a design which accepted them, or which let an aborted run write the result region, gets caught. A host write and altered width and constant inputs are injected mid-run. A design that sampled those inputs late, or let host writes through while busy, would return a wrong product or a modified operand.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int DIGIT = 32;

  localparam logic [1:0] RG_A = 2'd0;
  localparam logic [1:0] RG_B = 2'd1;
  localparam logic [1:0] RG_N = 2'd2;
  localparam logic [1:0] RG_R = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LDA,
    ST_U,
    ST_RD,
    ST_AC,
    ST_TOP,
    ST_SRD,
    ST_SAC
  } mm_state_e;
endpackage

// File: rtl/mm_word_ram.sv
module mm_word_ram #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  // port A: read/write, old data returned on a write
  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  // port B: read only
  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/mm_width_check.sv
module mm_width_check #(
  parameter int MAX_BITS = 2048,
  localparam int MAXW    = MAX_BITS / 32,
  localparam int CW      = $clog2(MAXW + 1)
) (
  input  logic [15:0]   width_bits,
  output logic          legal,
  output logic [CW-1:0] words
);
  localparam logic [31:0] MAXB = MAX_BITS;

  always_comb begin
    legal = ({16'b0, width_bits} >= 32'd256) &&
            ({16'b0, width_bits} <= MAXB) &&
            (width_bits[6:0] == 7'd0);
    words = CW'(width_bits >> 5);
  end
endmodule

// File: rtl/mm_digit_mac.sv
module mm_digit_mac (
  input  logic [31:0] t_in,
  input  logic [31:0] x_in,
  input  logic [31:0] y_in,
  input  logic [31:0] u_in,
  input  logic [31:0] n_in,
  input  logic [33:0] c_in,
  input  logic [31:0] ninv,
  output logic [65:0] sum,
  output logic [31:0] quot
);
  logic [63:0] xy;
  logic [63:0] un;
  logic [63:0] part;

  always_comb begin
    xy   = {32'b0, x_in} * {32'b0, y_in};
    un   = {32'b0, u_in} * {32'b0, n_in};
    part = {32'b0, t_in} + xy;
    // multiple of N that clears the low digit
    quot = part[31:0] * ninv;
    sum  = {2'b0, part} + {2'b0, un} + {32'b0, c_in};
  end
endmodule

// File: rtl/mont_mul.sv
module mont_mul
  import mm_pkg::*;
#(
  parameter int MAX_BITS = 2048,
  localparam int MAXW    = MAX_BITS / 32,
  localparam int IW      = $clog2(MAXW),
  localparam int CW      = $clog2(MAXW + 1),
  localparam int AW      = IW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [15:0]   width_bits,
  input  logic [31:0]   ninv,
  output logic          busy,
  output logic          done,
  output logic          err,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata
);
  mm_state_e   state_q;
  logic [CW-1:0] s_q, i_q, j_q, jm1;
  logic [31:0] ninv_q, u_q, ai_q;
  logic [33:0] carry_q;
  logic [2:0]  top_q;
  logic        first_q, phase_q, borrow_q, need_q;
  logic        busy_q, done_q, err_q;

  logic          w_legal;
  logic [CW-1:0] w_words;

  logic          op_a_we;
  logic [AW-1:0] op_a_addr, op_b_addr;
  logic [31:0]   op_a_wdata, op_a_rdata, op_b_rdata;
  logic          t_a_we;
  logic [IW-1:0] t_a_addr, t_b_addr;
  logic [31:0]   t_a_wdata, t_a_rdata, t_b_rdata;

  logic [31:0] mac_t, mac_x, mac_q;
  logic [65:0] mac_sum;
  logic [34:0] top_sum;
  logic [32:0] diff;
  logic        last_j;

  mm_width_check #(.MAX_BITS(MAX_BITS)) u_wchk (
    .width_bits (width_bits),
    .legal      (w_legal),
    .words      (w_words)
  );

  mm_word_ram #(.DW(32), .DEPTH(4 * MAXW)) u_opmem (
    .clk     (clk),
    .a_we    (op_a_we),
    .a_addr  (op_a_addr),
    .a_wdata (op_a_wdata),
    .a_rdata (op_a_rdata),
    .b_addr  (op_b_addr),
    .b_rdata (op_b_rdata)
  );

  mm_word_ram #(.DW(32), .DEPTH(MAXW)) u_tmem (
    .clk     (clk),
    .a_we    (t_a_we),
    .a_addr  (t_a_addr),
    .a_wdata (t_a_wdata),
    .a_rdata (t_a_rdata),
    .b_addr  (t_b_addr),
    .b_rdata (t_b_rdata)
  );

  mm_digit_mac u_mac (
    .t_in (mac_t),
    .x_in (mac_x),
    .y_in (op_a_rdata),
    .u_in (u_q),
    .n_in (op_b_rdata),
    .c_in (carry_q),
    .ninv (ninv_q),
    .sum  (mac_sum),
    .quot (mac_q)
  );

  always_comb begin
    jm1     = j_q - 1'b1;
    last_j  = (j_q == s_q - 1'b1);
    mac_t   = first_q ? 32'd0 : t_a_rdata;
    mac_x   = (state_q == ST_U) ? op_b_rdata : ai_q;
    top_sum = {32'b0, top_q} + {1'b0, carry_q};
    diff    = {1'b0, t_b_rdata} - {1'b0, op_b_rdata} - {32'b0, borrow_q};
  end

  // memory port steering
  always_comb begin
    op_a_we    = 1'b0;
    op_a_addr  = '0;
    op_a_wdata = '0;
    op_b_addr  = '0;
    t_a_we     = 1'b0;
    t_a_addr   = '0;
    t_a_wdata  = '0;
    t_b_addr   = '0;
    case (state_q)
      ST_IDLE: begin
        op_a_we    = host_we;
        op_a_addr  = host_addr;
        op_a_wdata = host_wdata;
      end
      ST_LDA: begin
        op_a_addr = {RG_B, IW'(0)};
        op_b_addr = {RG_A, i_q[IW-1:0]};
        t_a_addr  = '0;
      end
      ST_RD: begin
        op_a_addr = {RG_B, j_q[IW-1:0]};
        op_b_addr = {RG_N, j_q[IW-1:0]};
        t_a_addr  = j_q[IW-1:0];
      end
      ST_AC: begin
        t_a_we    = (j_q != '0);
        t_a_addr  = jm1[IW-1:0];
        t_a_wdata = mac_sum[31:0];
      end
      ST_TOP: begin
        t_a_we    = 1'b1;
        t_a_addr  = jm1[IW-1:0] + 1'b1;
        t_a_wdata = top_sum[31:0];
      end
      ST_SRD: begin
        op_b_addr = {RG_N, j_q[IW-1:0]};
        t_b_addr  = j_q[IW-1:0];
      end
      ST_SAC: begin
        op_a_we    = phase_q;
        op_a_addr  = {RG_R, j_q[IW-1:0]};
        op_a_wdata = need_q ? diff[31:0] : t_b_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      s_q      <= '0;
      i_q      <= '0;
      j_q      <= '0;
      ninv_q   <= '0;
      u_q      <= '0;
      ai_q     <= '0;
      carry_q  <= '0;
      top_q    <= '0;
      first_q  <= 1'b0;
      phase_q  <= 1'b0;
      borrow_q <= 1'b0;
      need_q   <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (w_legal) begin
              s_q     <= w_words;
              ninv_q  <= ninv;
              i_q     <= '0;
              j_q     <= '0;
              top_q   <= '0;
              first_q <= 1'b1;
              busy_q  <= 1'b1;
              err_q   <= 1'b0;
              state_q <= ST_LDA;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b1;
            end
          end
        end
        ST_LDA: state_q <= ST_U;
        ST_U: begin
          u_q     <= mac_q;
          ai_q    <= op_b_rdata;
          carry_q <= '0;
          j_q     <= '0;
          state_q <= ST_RD;
        end
        ST_RD: state_q <= ST_AC;
        ST_AC: begin
          carry_q <= mac_sum[65:32];
          if (last_j) begin
            state_q <= ST_TOP;
          end else begin
            j_q     <= j_q + 1'b1;
            state_q <= ST_RD;
          end
        end
        ST_TOP: begin
          top_q   <= top_sum[34:32];
          first_q <= 1'b0;
          if (i_q == s_q - 1'b1) begin
            j_q      <= '0;
            phase_q  <= 1'b0;
            borrow_q <= 1'b0;
            state_q  <= ST_SRD;
          end else begin
            i_q     <= i_q + 1'b1;
            state_q <= ST_LDA;
          end
        end
        ST_SRD: state_q <= ST_SAC;
        ST_SAC: begin
          borrow_q <= diff[32];
          if (last_j) begin
            if (!phase_q) begin
              need_q   <= (top_q != 3'd0) || !diff[32];
              phase_q  <= 1'b1;
              j_q      <= '0;
              borrow_q <= 1'b0;
              state_q  <= ST_SRD;
            end else begin
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else begin
            j_q     <= j_q + 1'b1;
            state_q <= ST_SRD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign err        = err_q;
  assign host_rdata = op_a_rdata;
endmodule

// File: rtl/mm_mont_chk.sv
module mm_mont_chk #(
  parameter int MAX_BITS = 2048
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [15:0] width_bits,
  input logic        busy,
  input logic        done,
  input logic        err
);
  localparam logic [31:0] MAXB = MAX_BITS;
  logic bad_w;
  assign bad_w = ({16'b0, width_bits} < 32'd256) ||
                 ({16'b0, width_bits} > MAXB) ||
                 (width_bits[6:0] != 7'd0);

  p_bad_width_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && bad_w) |=> (done && err && !busy));

  p_good_start_r4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !bad_w) |=> (busy && !err));

  p_busy_exit_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_err_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  p_err_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> busy);
endmodule

bind mont_mul mm_mont_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .width_bits (width_bits),
  .busy       (busy),
  .done       (done),
  .err        (err)
);

// File: tb/sim_mont_mul.sv
module sim_mont_mul;
  localparam int PERIOD   = 10;
  localparam int MAX_BITS = 2048;
  localparam int IW       = $clog2(MAX_BITS / 32);
  localparam int AW       = IW + 2;
  localparam int BW       = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [15:0]   width_bits = '0;
  logic [31:0]   ninv = '0;
  logic          busy, done, err;
  logic          host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  mont_mul #(.MAX_BITS(MAX_BITS)) u0 (
    .clk(clk), .rst(rst), .start(start), .width_bits(width_bits), .ninv(ninv),
    .busy(busy), .done(done), .err(err), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always #(PERIOD / 2) clk = ~clk;

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // bit-serial reduction: halve n times modulo odd N
  function automatic logic [BW-1:0] ref_mont(input logic [BW-1:0] a, b, n, input int nb);
    logic [2*BW-1:0] p;
    logic [BW:0] x;
    p = {{BW{1'b0}}, a} * {{BW{1'b0}}, b};
    p = p % {{BW{1'b0}}, n};
    x = p[BW:0];
    for (int k = 0; k < nb; k++) begin
      if (x[0]) x = x + {1'b0, n};
      x = x >> 1;
    end
    return x[BW-1:0];
  endfunction

  function automatic logic [31:0] neg_inv(input logic [31:0] n0);
    logic [31:0] v;
    v = n0;
    for (int k = 0; k < 4; k++) v = v * (32'd2 - n0 * v);
    return 32'd0 - v;
  endfunction

  task automatic host_wr(input logic [1:0] rg, input int idx, input logic [31:0] d);
    @(negedge clk);
    host_we    = 1'b1;
    host_addr  = {rg, idx[IW-1:0]};
    host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] rg, input int idx, output logic [31:0] d);
    @(negedge clk);
    host_addr = {rg, idx[IW-1:0]};
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic pulse_start(input int w, input logic [31:0] nv);
    @(negedge clk);
    start      = 1'b1;
    width_bits = w[15:0];
    ninv       = nv;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int cnt = 0;
    while (!done && cnt < 50000) begin
      @(negedge clk);
      cnt++;
    end
    chk(done, req, {31'b0, done}, 32'd1);
  endtask

  task automatic make_ops(input int w, input int kind, output logic [BW-1:0] a,
                          output logic [BW-1:0] b, output logic [BW-1:0] n);
    a = '0; b = '0; n = '0;
    for (int k = 0; k < w / 32; k++) begin
      n[32*k +: 32] = rnd();
      a[32*k +: 32] = rnd();
      b[32*k +: 32] = rnd();
    end
    n[w-1] = 1'b1;
    n[0]   = 1'b1;
    a = a % n;
    b = b % n;
    if (kind == 1) a = '0;
    if (kind == 2) begin a = n - 1; b = n - 1; end
  endtask

  task automatic load_ops(input int w, input logic [BW-1:0] a, b, n);
    for (int k = 0; k < w / 32; k++) begin
      host_wr(2'd0, k, a[32*k +: 32]);
      host_wr(2'd1, k, b[32*k +: 32]);
      host_wr(2'd2, k, n[32*k +: 32]);
    end
  endtask

  task automatic cmp_result(input int w, input logic [BW-1:0] exp, input string req);
    logic [31:0] d;
    for (int k = 0; k < w / 32; k++) begin
      host_rd(2'd3, k, d);
      chk(d == exp[32*k +: 32], req, d, exp[32*k +: 32]);
    end
  endtask

  // R1 R7 R9: full multiply against the model
  task automatic t_mul(input int w, input int kind, input string req);
    logic [BW-1:0] a, b, n, exp;
    make_ops(w, kind, a, b, n);
    load_ops(w, a, b, n);
    exp = ref_mont(a, b, n, w);
    pulse_start(w, neg_inv(n[31:0]));
    chk(busy == 1'b1, "R4 busy after start", {31'b0, busy}, 32'd1);
    wait_done("R4 done");
    chk(err == 1'b0 && busy == 1'b0, "R5 err low after good run", {30'b0, err, busy}, 32'd0);
    cmp_result(w, exp, req);
  endtask

  // R2: illegal width
  task automatic t_bad(input int w);
    logic [31:0] d;
    for (int k = 0; k < 4; k++) host_wr(2'd3, k, 32'hA5A5_0000 + k);
    pulse_start(w, 32'h1);
    chk(done && err && !busy, "R2 illegal width flagged", {29'b0, done, err, busy}, 32'd6);
    @(negedge clk);
    chk(!busy, "R2 busy stays low", {31'b0, busy}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      host_rd(2'd3, k, d);
      chk(d == 32'hA5A5_0000 + k, "R2 result untouched", d, 32'hA5A5_0000 + k);
    end
  endtask

  // R6 R8: host write and input changes during busy
  task automatic t_ignore();
    logic [BW-1:0] a, b, n, exp;
    logic [31:0] d;
    make_ops(256, 0, a, b, n);
    load_ops(256, a, b, n);
    exp = ref_mont(a, b, n, 256);
    pulse_start(256, neg_inv(n[31:0]));
    width_bits = 16'd384;
    ninv       = 32'hFFFF_0001;
    host_wr(2'd0, 0, 32'hDEAD_BEEF);
    wait_done("R8 done");
    cmp_result(256, exp, "R8 inputs sampled at start");
    host_rd(2'd0, 0, d);
    chk(d == a[31:0], "R6 host write ignored while busy", d, a[31:0]);
  endtask

  // R3: region map and read latency
  task automatic t_map();
    logic [31:0] d;
    for (int r = 0; r < 4; r++) host_wr(r[1:0], 3, 32'h1000_0000 * (r + 1) + 32'h33);
    for (int r = 0; r < 4; r++) begin
      host_rd(r[1:0], 3, d);
      chk(d == 32'h1000_0000 * (r + 1) + 32'h33, "R3 region map", d,
          32'h1000_0000 * (r + 1) + 32'h33);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err, "R4 reset state", {29'b0, busy, done, err}, 32'd0);
    t_map();
    t_mul(256, 0, "R1 product 256");
    t_mul(512, 0, "R1 product 512");
    t_mul(256, 1, "R9 zero operand");
    t_mul(256, 2, "R7 max operands 256");
    t_mul(512, 2, "R7 max operands 512");
    t_bad(128);
    t_bad(320);
    t_bad(2176);
    t_mul(512, 0, "R5 run after error");
    t_ignore();
    t_mul(256, 0, "R1 product 256 again");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule